// File: doc/BRIEF.md
# Precision-Cascaded Convolution Max-Pool Unit

This unit produces one max-pooled convolution result for a 2x2 pooling window while doing most of its arithmetic at reduced precision. A single start pulse presents the activation taps of all four candidate output pixels, together with one weight vector that all four candidates share. Every unsigned activation is split into a high-order and a low-order bit group. In a first pass, a single serial multiplier-accumulator forms a coarse dot product for each candidate from the high-order groups only. The candidate with the largest coarse sum is taken as the pooling winner. A second pass then folds in the low-order groups for that winner alone.

Any bit group that is zero is skipped by a priority search over a mask of non-zero groups, so it takes no clock cycle. The unit reports three things: the winner index, the winner's exact dot product, and the number of multiply-accumulate cycles that the window consumed. The caller drives parallel inputs and a one-cycle start, then waits for a one-cycle done. Bias, activation functions, memory fetch and channel tiling belong to the surrounding datapath.

Top module: `pcmp_unit`

## Requirements
- R1: After reset, busy, done, win_idx, result and mac_cycles are all zero.
- R2: A start pulse is accepted only while busy is low, and the inputs are captured in that cycle. A start pulse while busy is high is ignored: the window in progress completes with its own captured inputs, and no extra done follows.
- R3: The winner is the candidate with the largest coarse sum. A candidate's coarse sum is the sum over its taps of the high group (activation bits [7:4], unsigned) times the signed 8-bit weight. On equal coarse sums, the lowest candidate index wins. Candidate c uses tap t at act_i bits [(c*9+t)*8 +: 8], and tap t uses weight bits wgt_i[t*8 +: 8].
- R4: result is the exact signed dot product of the winner's full 8-bit activations with the weights. It equals the coarse sum shifted left by 4, plus the low-group (bits [3:0]) sum. The winner is the one from R3 even when another candidate has a larger exact product.
- R5: mac_cycles equals the number of non-zero high groups over all 36 taps, plus the number of non-zero low groups among the winner's 9 taps. An all-zero window reports 0.
- R6: done is high for exactly one cycle, and busy is low while done is high. win_idx, result and mac_cycles change only in the cycle done is high, and hold until the next done.
- R7: done rises mac_cycles + 3 clock edges after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a window |
| act_i | input | 288 | Activations, 4 candidates x 9 taps x 8 bits unsigned |
| wgt_i | input | 72 | Shared weights, 9 taps x 8 bits signed |
| busy | output | 1 | A window is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| win_idx | output | 2 | Index of the pooling winner |
| result | output | 21 | Exact signed dot product of the winner |
| mac_cycles | output | 6 | MAC cycles spent on the last window |

## Verification
The assertions watch every cycle for four things. They check that start is honoured only when the unit is idle, and that done is a lone pulse outside busy. They check that the outputs hold between done pulses. Through a counter in the checker, they also tie the start-to-done latency to the reported cycle count. Which candidate wins, the exact value of its dot product, how ties break, and whether zero groups really vanish from the count all depend on data. The bench shows these only by its scenarios against a reference model: all-zero, saturated, tied, deliberately misleading coarse results, negative weights, random sparse windows, and a start injected mid-window.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_PICK = 2'd2,
    ST_LO   = 2'd3
  } pcmp_state_e;
endpackage

// File: rtl/pcmp_first_set.sv
// Lowest-index set bit of a request mask.
module pcmp_first_set #(
  parameter int N    = 36,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |mask;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pcmp_mac.sv
// One unsigned-group by signed-weight product added to an accumulator.
module pcmp_mac #(
  parameter int GW    = 4,
  parameter int WGT_W = 8,
  parameter int ACC_W = 21
) (
  input  logic        [GW-1:0]    grp,
  input  logic signed [WGT_W-1:0] wgt,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic signed [ACC_W-1:0] acc_out
);
  logic signed [GW+WGT_W:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  assign prod     = $signed({1'b0, grp}) * wgt;
  assign prod_ext = ACC_W'(prod);
  assign acc_out  = acc_in + prod_ext;
endmodule

// File: rtl/pcmp_argmax.sv
// Largest signed value; the lowest index wins a tie.
module pcmp_argmax #(
  parameter int CANDS = 4,
  parameter int W     = 17,
  localparam int IW   = (CANDS > 1) ? $clog2(CANDS) : 1
) (
  input  logic [CANDS*W-1:0] vals,
  output logic [IW-1:0]      idx
);
  logic signed [W-1:0] best;

  always_comb begin
    best = $signed(vals[W-1:0]);
    idx  = '0;
    for (int i = 1; i < CANDS; i++) begin
      if ($signed(vals[i*W +: W]) > best) begin
        best = $signed(vals[i*W +: W]);
        idx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit
  import pcmp_pkg::*;
#(
  parameter int CANDS = 4,
  parameter int TAPS  = 9,
  parameter int ACT_W = 8,
  parameter int WGT_W = 8,
  parameter int GRP_W = 4,
  localparam int NHI      = CANDS * TAPS,
  localparam int HI_W     = ACT_W - GRP_W,
  localparam int MG_W     = (HI_W > GRP_W) ? HI_W : GRP_W,
  localparam int HI_ACC_W = HI_W + WGT_W + 1 + $clog2(TAPS),
  localparam int RES_W    = ACT_W + WGT_W + 1 + $clog2(TAPS),
  localparam int CIDX_W   = (CANDS > 1) ? $clog2(CANDS) : 1,
  localparam int TIDX_W   = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int HI_IDX_W = (NHI > 1) ? $clog2(NHI) : 1,
  localparam int CNT_W    = $clog2(NHI + TAPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NHI*ACT_W-1:0]    act_i,
  input  logic [TAPS*WGT_W-1:0]   wgt_i,
  output logic                    busy,
  output logic                    done,
  output logic [CIDX_W-1:0]       win_idx,
  output logic signed [RES_W-1:0] result,
  output logic [CNT_W-1:0]        mac_cycles
);
  pcmp_state_e state;

  logic        [ACT_W-1:0]    act_q [NHI];
  logic signed [WGT_W-1:0]    wgt_q [TAPS];
  logic signed [HI_ACC_W-1:0] hi_acc [CANDS];
  logic signed [RES_W-1:0]    fin_acc;
  logic [NHI-1:0]             hi_mask;
  logic [NHI-1:0]             hi_mask_in;
  logic [TAPS-1:0]            lo_mask;
  logic [TAPS-1:0]            lo_mask_win;
  logic [CIDX_W-1:0]          win_run;
  logic [CNT_W-1:0]           run_cnt;

  logic                       hi_found;
  logic [HI_IDX_W-1:0]        hi_idx;
  logic                       lo_found;
  logic [TIDX_W-1:0]          lo_idx;
  logic [CIDX_W-1:0]          hi_cand;
  logic [TIDX_W-1:0]          hi_tap;
  logic [HI_IDX_W-1:0]        lo_pos;
  logic [CIDX_W-1:0]          am_idx;
  logic [CANDS*HI_ACC_W-1:0]  hi_flat;

  logic        [MG_W-1:0]     mac_grp;
  logic signed [WGT_W-1:0]    mac_wgt;
  logic signed [RES_W-1:0]    mac_acc;
  logic signed [RES_W-1:0]    mac_out;

  // Non-zero high groups of the incoming window, built at capture time.
  for (genvar j = 0; j < NHI; j++) begin : g_hmask
    assign hi_mask_in[j] = |act_i[j*ACT_W+GRP_W +: HI_W];
  end

  for (genvar c = 0; c < CANDS; c++) begin : g_flat
    assign hi_flat[c*HI_ACC_W +: HI_ACC_W] = hi_acc[c];
  end

  // Non-zero low groups of the candidate the comparator currently favours.
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      lo_mask_win[t] = |act_q[HI_IDX_W'(int'(am_idx) * TAPS + t)][GRP_W-1:0];
    end
  end

  assign hi_cand = CIDX_W'(int'(hi_idx) / TAPS);
  assign hi_tap  = TIDX_W'(int'(hi_idx) % TAPS);
  assign lo_pos  = HI_IDX_W'(int'(win_run) * TAPS + int'(lo_idx));

  pcmp_first_set #(.N(NHI)) u_hi_pick (
    .mask (hi_mask),
    .found(hi_found),
    .idx  (hi_idx)
  );

  pcmp_first_set #(.N(TAPS)) u_lo_pick (
    .mask (lo_mask),
    .found(lo_found),
    .idx  (lo_idx)
  );

  pcmp_argmax #(.CANDS(CANDS), .W(HI_ACC_W)) u_argmax (
    .vals(hi_flat),
    .idx (am_idx)
  );

  // Operand steering into the single shared MAC.
  always_comb begin
    if (state == ST_LO) begin
      mac_grp = MG_W'(act_q[lo_pos][GRP_W-1:0]);
      mac_wgt = wgt_q[lo_idx];
      mac_acc = fin_acc;
    end else begin
      mac_grp = MG_W'(act_q[hi_idx][ACT_W-1:GRP_W]);
      mac_wgt = wgt_q[hi_tap];
      mac_acc = RES_W'(hi_acc[hi_cand]);
    end
  end

  pcmp_mac #(.GW(MG_W), .WGT_W(WGT_W), .ACC_W(RES_W)) u_mac (
    .grp    (mac_grp),
    .wgt    (mac_wgt),
    .acc_in (mac_acc),
    .acc_out(mac_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hi_mask    <= '0;
      lo_mask    <= '0;
      fin_acc    <= '0;
      win_run    <= '0;
      run_cnt    <= '0;
      done       <= 1'b0;
      win_idx    <= '0;
      result     <= '0;
      mac_cycles <= '0;
      for (int c = 0; c < CANDS; c++) hi_acc[c] <= '0;
      for (int j = 0; j < NHI; j++) act_q[j] <= '0;
      for (int t = 0; t < TAPS; t++) wgt_q[t] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            for (int j = 0; j < NHI; j++) act_q[j] <= act_i[j*ACT_W +: ACT_W];
            for (int t = 0; t < TAPS; t++) wgt_q[t] <= $signed(wgt_i[t*WGT_W +: WGT_W]);
            for (int c = 0; c < CANDS; c++) hi_acc[c] <= '0;
            hi_mask <= hi_mask_in;
            run_cnt <= '0;
            state   <= ST_HI;
          end
        end
        ST_HI: begin
          if (hi_found) begin
            hi_acc[hi_cand]  <= mac_out[HI_ACC_W-1:0];
            hi_mask[hi_idx]  <= 1'b0;
            run_cnt          <= run_cnt + 1'b1;
          end else begin
            state <= ST_PICK;
          end
        end
        ST_PICK: begin
          win_run <= am_idx;
          fin_acc <= RES_W'(hi_acc[am_idx]) <<< GRP_W;
          lo_mask <= lo_mask_win;
          state   <= ST_LO;
        end
        ST_LO: begin
          if (lo_found) begin
            fin_acc         <= mac_out;
            lo_mask[lo_idx] <= 1'b0;
            run_cnt         <= run_cnt + 1'b1;
          end else begin
            result     <= fin_acc;
            win_idx    <= win_run;
            mac_cycles <= run_cnt;
            done       <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pcmp_unit_chk.sv
module pcmp_unit_chk #(
  parameter int CANDS  = 4,
  parameter int TAPS   = 9,
  parameter int RES_W  = 21,
  parameter int CNT_W  = 6,
  parameter int CIDX_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [CIDX_W-1:0]       win_idx,
  input logic signed [RES_W-1:0] result,
  input logic [CNT_W-1:0]        mac_cycles
);
  logic       past_ok;
  logic [7:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      lat_cnt <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!busy && start) lat_cnt <= 8'd1;
      else if (busy)      lat_cnt <= lat_cnt + 8'd1;
    end
  end

  p_start_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_idle_stays_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_hold_outputs_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done) |-> ($stable(result) && $stable(win_idx) && $stable(mac_cycles)));

  p_cycle_bound_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(mac_cycles) <= CANDS * TAPS + TAPS));

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(lat_cnt) == int'(mac_cycles) + 4));
endmodule

bind pcmp_unit pcmp_unit_chk #(
  .CANDS (CANDS),
  .TAPS  (TAPS),
  .RES_W (RES_W),
  .CNT_W (CNT_W),
  .CIDX_W(CIDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .win_idx   (win_idx),
  .result    (result),
  .mac_cycles(mac_cycles)
);

// File: tb/pcmp_unit_bench.sv
module pcmp_unit_bench;
  localparam int CANDS = 4;
  localparam int TAPS  = 9;
  localparam int ACT_W = 8;
  localparam int WGT_W = 8;
  localparam int NHI   = CANDS * TAPS;
  localparam int RES_W = 21;
  localparam int CNT_W = 6;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    start = 1'b0;
  logic [NHI*ACT_W-1:0]    act_i = '0;
  logic [TAPS*WGT_W-1:0]   wgt_i = '0;
  logic                    busy;
  logic                    done;
  logic [1:0]              win_idx;
  logic signed [RES_W-1:0] result;
  logic [CNT_W-1:0]        mac_cycles;

  always #2 clk = ~clk;

  pcmp_unit u_pcmp_unit (
    .clk(clk), .rst(rst), .start(start), .act_i(act_i), .wgt_i(wgt_i),
    .busy(busy), .done(done), .win_idx(win_idx), .result(result),
    .mac_cycles(mac_cycles)
  );

  typedef struct {
    int    idx;
    int    res;
    int    cyc;
    int    t0;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   act [NHI];
  int   wgt [TAPS];
  int   last_res = 0;
  int   last_idx = 0;
  int   last_cyc = 0;
  bit   chk_hold = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic pack_inputs();
    for (int j = 0; j < NHI; j++) act_i[j*ACT_W +: ACT_W] = act[j][ACT_W-1:0];
    for (int t = 0; t < TAPS; t++) wgt_i[t*WGT_W +: WGT_W] = wgt[t][WGT_W-1:0];
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    int hs [CANDS];
    int best;
    best = 0;
    for (int c = 0; c < CANDS; c++) begin
      hs[c] = 0;
      for (int t = 0; t < TAPS; t++) hs[c] += (act[c*TAPS+t] >> 4) * wgt[t];
    end
    for (int c = 1; c < CANDS; c++) if (hs[c] > hs[best]) best = c;
    e.idx = best;
    e.res = 0;
    e.cyc = 0;
    for (int t = 0; t < TAPS; t++) begin
      e.res += act[best*TAPS+t] * wgt[t];
      if ((act[best*TAPS+t] & 15) != 0) e.cyc++;
    end
    for (int j = 0; j < NHI; j++) if ((act[j] >> 4) != 0) e.cyc++;
    e.tag = tag;
    e.t0  = 0;
    return e;
  endfunction

  // Driver: model, push, start, and optionally inject a start while busy.
  task automatic run_window(input string tag, input bit inject);
    exp_t e;
    e = model(tag);
    @(negedge clk);
    pack_inputs();
    e.t0 = cyc;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (2) @(negedge clk);
      check(busy == 1'b1, "R2", "busy before injected start", int'(busy), 1);
      for (int j = 0; j < NHI; j++) act_i[j*ACT_W +: ACT_W] = 8'hA5;
      wgt_i = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(posedge clk); while (q.size() != 0);
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (chk_hold) begin
        chk_hold = 0;
        check(done == 1'b0, "R6", "done width", int'(done), 0);
        check(int'(result) == last_res && int'(win_idx) == last_idx &&
              int'(mac_cycles) == last_cyc, "R6", "held result", int'(result), last_res);
      end
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "done with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(win_idx) == e.idx, "R3", {e.tag, " winner"}, int'(win_idx), e.idx);
          check(int'(result) == e.res, "R4", {e.tag, " result"}, int'(result), e.res);
          check(int'(mac_cycles) == e.cyc, "R5", {e.tag, " mac cycles"}, int'(mac_cycles), e.cyc);
          check(cyc - e.t0 - 1 == e.cyc + 3, "R7", {e.tag, " latency"}, cyc - e.t0 - 1, e.cyc + 3);
        end
        last_res = int'(result);
        last_idx = int'(win_idx);
        last_cyc = int'(mac_cycles);
        chk_hold = 1;
      end
    end
  end

  task automatic clear_all();
    for (int j = 0; j < NHI; j++) act[j] = 0;
    for (int t = 0; t < TAPS; t++) wgt[t] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(win_idx == '0, "R1", "win_idx", int'(win_idx), 0);
    check(result == '0, "R1", "result", int'(result), 0);
    check(mac_cycles == '0, "R1", "mac_cycles", int'(mac_cycles), 0);

    // R5: all-zero window costs no MAC cycle
    clear_all();
    run_window("zeros", 0);

    // R5: saturated window, every group non-zero, all tied -> index 0 (R3)
    for (int j = 0; j < NHI; j++) act[j] = 255;
    for (int t = 0; t < TAPS; t++) wgt[t] = 127;
    run_window("saturated", 0);

    // R3 tie on coarse sums with differing low groups: lowest index wins
    clear_all();
    for (int t = 0; t < TAPS; t++) wgt[t] = 1;
    for (int t = 0; t < TAPS; t++) begin
      act[1*TAPS+t] = 8'h30;
      act[2*TAPS+t] = 8'h3F;
    end
    run_window("tie", 0);

    // R4 coarse winner is not the exact maximum
    clear_all();
    for (int t = 0; t < TAPS; t++) wgt[t] = 10;
    act[1*TAPS] = 8'h20;
    act[2*TAPS] = 8'h1F;
    for (int t = 1; t < TAPS; t++) act[2*TAPS+t] = 8'h0F;
    run_window("misleading", 0);

    // R3/R4 negative weights
    for (int j = 0; j < NHI; j++) act[j] = (j * 37 + 11) % 256;
    for (int t = 0; t < TAPS; t++) wgt[t] = -100 + t * 3;
    run_window("negative", 0);

    // R2 start while busy is ignored
    for (int j = 0; j < NHI; j++) act[j] = (j * 53 + 7) % 256;
    for (int t = 0; t < TAPS; t++) wgt[t] = t * 29 - 120;
    run_window("inject", 1);
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && q.size() == 0, "R2", "idle after ignored start",
          int'(busy), 0);

    // Random sparse windows
    for (int n = 0; n < 30; n++) begin
      for (int j = 0; j < NHI; j++) begin
        int r;
        r = int'($urandom % 4);
        if (r == 0)      act[j] = 0;
        else if (r == 1) act[j] = int'($urandom % 16);
        else if (r == 2) act[j] = int'($urandom % 16) * 16;
        else             act[j] = int'($urandom % 256);
      end
      for (int t = 0; t < TAPS; t++) wgt[t] = int'($urandom % 256) - 128;
      run_window("random", 0);
    end

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule